// File: doc/BRIEF.md
# Pipelined Table-Based Ones Counter

This block counts the set bits of a 64-bit word and returns the total as a 7-bit number (0 to 64). It takes a fresh word on every rising clock edge and returns one result per edge, so a stream of words can be fed with no gaps. Each result appears a fixed number of cycles after its word.

The word is split into five 12-bit slices and a 4-bit tail. Each slice indexes a 4096-entry table whose 4-bit entries hold the number of ones in that index. The table contents are computed by a function when the design is elaborated. The tail is counted with plain logic. The six partial counts are then summed by a registered tree of two-input adders. A valid flag moves alongside the data through every stage, so the output flag marks exactly the cycles that carry a real count.

Top module: `popcount_table_pipe`

## Requirements
- R1: For every accepted word, `out_count` equals the number of ones in that word. The count is unsigned binary on 7 bits and is never above 64.
- R2: A word sampled with `in_valid` high at rising edge n produces `out_valid` high and its count after edge n+3. The latency is four register stages.
- R3: Words presented on consecutive cycles each yield their own count on consecutive cycles, in the same order. There is no stall or bubble.
- R4: A cycle sampled with `in_valid` low produces `out_valid` low four stages later, whatever the value on `in_data`.
- R5: While `rst_n` is low, `out_valid` is low. It stays low after release until the first valid word has passed through the pipeline.
- R6: An all-zeros word counts 0 and an all-ones word counts 64.
- R7: A word with exactly one bit set counts 1 for each of the 64 positions. This covers slice edges and the tail bits 60 to 63.
- R8: Each 12-bit slice (bits 12k to 12k+11, k = 0..4) is counted through its table up to the full value 12. A fully set slice alone gives 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a word to count |
| in_data | input | 64 | Word whose ones are counted |
| out_valid | output | 1 | Marks `out_count` as a real result |
| out_count | output | 7 | Number of ones in the matching input word |

## Verification
Every result is due exactly four rising edges after the edge that sampled its word. This holds for the count and for the valid flag alike, and it holds through reset release. The bench drives inputs on falling edges. It keeps a four-deep history of expected flags and counts, advanced by one entry on each falling edge. Each output is compared with the entry that has aged four slots, before the next input is driven. Streams run back to back and with gaps, so each slot is checked in its own cycle.

// File: rtl/popcount_table_pipe.sv
module popcount_table_pipe #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_data,
  output logic                       out_valid,
  output logic [$clog2(DATA_W+1)-1:0] out_count
);

  localparam int CNT_W       = $clog2(DATA_W + 1);
  localparam int ENT_W       = $clog2(SLICE_W + 1);
  localparam int TABLE_DEPTH = 1 << SLICE_W;
  localparam int NUM_SLICES  = DATA_W / SLICE_W;
  localparam int REM_W       = DATA_W - NUM_SLICES * SLICE_W;
  localparam int NUM_LEAF    = NUM_SLICES + ((REM_W > 0) ? 1 : 0);
  localparam int LEVELS      = $clog2(NUM_LEAF);
  localparam int LAT         = LEVELS + 1;

  function automatic logic [TABLE_DEPTH*ENT_W-1:0] build_table();
    logic [TABLE_DEPTH*ENT_W-1:0] t;
    int c;
    t = '0;
    for (int a = 0; a < TABLE_DEPTH; a++) begin
      c = 0;
      for (int b = 0; b < SLICE_W; b++) c += (a >> b) & 1;
      t[a*ENT_W +: ENT_W] = ENT_W'(c);
    end
    return t;
  endfunction

  localparam logic [TABLE_DEPTH*ENT_W-1:0] ONES_TABLE = build_table();

  logic [CNT_W-1:0] tree [LEVELS+1][NUM_LEAF];
  logic [LAT-1:0]   vpipe;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [ENT_W-1:0] entry;
    assign entry = ONES_TABLE[int'(in_data[s*SLICE_W +: SLICE_W])*ENT_W +: ENT_W];
    always_ff @(posedge clk) tree[0][s] <= CNT_W'(entry);
  end

  if (REM_W > 0) begin : g_tail
    logic [CNT_W-1:0] tail_cnt;
    always_comb begin
      tail_cnt = '0;
      for (int b = 0; b < REM_W; b++)
        tail_cnt += CNT_W'(in_data[NUM_SLICES*SLICE_W + b]);
    end
    always_ff @(posedge clk) tree[0][NUM_SLICES] <= tail_cnt;
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_level
    localparam int PREV = (NUM_LEAF + (1 << (l-1)) - 1) >> (l-1);
    localparam int CUR  = (NUM_LEAF + (1 << l) - 1) >> l;
    for (genvar j = 0; j < NUM_LEAF; j++) begin : g_node
      if (j < CUR && 2*j+1 < PREV) begin : g_add
        always_ff @(posedge clk) tree[l][j] <= tree[l-1][2*j] + tree[l-1][2*j+1];
      end else if (j < CUR) begin : g_pass
        always_ff @(posedge clk) tree[l][j] <= tree[l-1][2*j];
      end else begin : g_idle
        always_ff @(posedge clk) tree[l][j] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-2:0], in_valid};

  assign out_valid = vpipe[LAT-1];
  assign out_count = tree[LEVELS][0];

  int unsigned age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         age <= 0;
    else if (age < LAT) age <= age + 1;

  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= CNT_W'(DATA_W));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == LAT) |-> out_valid == $past(in_valid, LAT));

  a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
    (age == LAT && out_valid) |-> out_count == CNT_W'($countones($past(in_data, LAT))));

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_leaf_chk
    a_r8_leaf_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 1) |-> tree[0][s] <= CNT_W'(SLICE_W));
  end

endmodule

// File: tb/test_popcount_table_pipe.sv
module test_popcount_table_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int NV = 10;

  localparam logic [63:0] STIM_WORD [NV] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001,
    64'h8000_0000_0000_0000, 64'h0000_0000_0000_0FFF, 64'hF000_0000_0000_0000,
    64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_00FF_F000, 64'h1111_1111_1111_1111,
    64'hFFFF_FFFF_FFFF_FFFE };
  localparam int STIM_EXP [NV] = '{0, 64, 1, 1, 12, 4, 32, 12, 16, 63};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [6:0]  out_count;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic  hv [LAT];
  int    hc [LAT];
  string ht [LAT];

  popcount_table_pipe i_popcount_table_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_count(out_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_count(logic [63:0] w);
    int c = 0;
    for (int b = 0; b < 64; b++) c += int'(w[b]);
    return c;
  endfunction

  task automatic step(input logic v, input logic [63:0] d, input string tag);
    @(negedge clk);
    n_tests++;
    if (out_valid !== hv[LAT-1]) begin
      n_fail++;
      $display("FAIL %s valid: actual %b expected %b", ht[LAT-1], out_valid, hv[LAT-1]);
    end
    if (hv[LAT-1] === 1'b1) begin
      n_tests++;
      if (out_count !== 7'(hc[LAT-1])) begin
        n_fail++;
        $display("FAIL %s count: actual %0d expected %0d", ht[LAT-1], out_count, hc[LAT-1]);
      end
    end
    for (int k = LAT-1; k > 0; k--) begin
      hv[k] = hv[k-1]; hc[k] = hc[k-1]; ht[k] = ht[k-1];
    end
    hv[0] = v; hc[0] = ref_count(d); ht[0] = tag;
    in_valid = v;
    in_data  = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < LAT; k++) begin hv[k] = 0; hc[k] = 0; ht[k] = "R5"; end
    // R5: reset holds the output flag low, including after release
    for (int i = 0; i < 3; i++) step(1'b0, 64'hFFFF, "R5");
    rst_n = 1;
    for (int i = 0; i < LAT; i++) step(1'b0, 64'h1234, "R5");

    // Vector table, back to back (R1 R3 R6 R8)
    for (int i = 0; i < NV; i++) begin
      if (ref_count(STIM_WORD[i]) != STIM_EXP[i]) begin
        n_fail++;
        $display("FAIL R1 table entry %0d: actual %0d expected %0d", i, ref_count(STIM_WORD[i]), STIM_EXP[i]);
      end
      step(1'b1, STIM_WORD[i], (i < 2) ? "R6" : (i == 4 || i == 7) ? "R8" : "R3");
    end

    // R8: each slice fully set on its own
    for (int s = 0; s < 5; s++) step(1'b1, 64'hFFF << (12*s), "R8");

    // R7: walking single bit
    for (int b = 0; b < 64; b++) step(1'b1, 64'h1 << b, "R7");

    // R4: gaps with live data on invalid cycles
    for (int i = 0; i < 16; i++) step(i[0], {$urandom, $urandom}, "R4");

    // R1 R3: random back-to-back stream
    for (int i = 0; i < 200; i++) step(1'b1, {$urandom, $urandom}, "R1");

    // R2: drain, then check the exact latency of one lone word
    for (int i = 0; i < LAT; i++) step(1'b0, '0, "R2");
    step(1'b1, 64'h00F0_0000_0000_0F0F, "R2");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '1, "R2");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule